// File: doc/BRIEF.md
# Activation-Counting Victim Row Refresher

This block sits beside the command path of one DRAM bank. It watches each row-activate command and keeps a saturating activation count for every row. The counts cover one window: a window tick from the memory controller clears all of them. When a row is activated heavily enough, the rows on either side of it are at risk of losing charge. These rows are called victims, and the block schedules an extra targeted refresh for them, so the controller does not have to raise the refresh rate of the whole bank.

A row is treated as an aggressor when its own count reaches a threshold set at run time. A victim is also flagged when the counts of its two neighbours add up to that threshold. Victim row addresses go into a four-entry queue with duplicate suppression. The queue presents them to the command scheduler one at a time over a valid/ready handshake. Each victim is scheduled as a normal refresh of that row address. The scheduler, the bank timing and the array itself are outside this block.

The queue side is a two-state machine. `Q_EMPTY` means no victim is waiting and `ref_valid` is low. `Q_OFFER` means the oldest victim is on `ref_row` with `ref_valid` high. The transition `Q_EMPTY -> Q_OFFER` is taken when a victim is written into an empty queue. The transition `Q_OFFER -> Q_EMPTY` is taken when a handshake removes the last entry and no victim is written in the same cycle. Otherwise the state is held.

Top module: `rvr_victim_refresher`

## Requirements
- R1: Each cycle with `act_valid` high adds one to the count of row `act_row`. The count saturates at its all-ones value. A row that is activated `mac_limit - 1` times in a window, with no help from its neighbours, raises no request.
- R2: When `mac_limit` is nonzero and an activation brings the count of row r to `mac_limit` or above, rows r-1 and r+1 are queued. Both are written at the clock edge that takes the activation. When both are new, r-1 is queued ahead of r+1.
- R3: When an activation of a neighbour makes count(v-1)+count(v+1) reach `mac_limit` or above, victim v is queued, even though neither count reaches the limit by itself. The activated neighbour's count clears. The other neighbour's count also clears when its contribution was needed to reach the limit.
- R4: When an activation raises a request, the activated row's count returns to zero. The row must then reach `mac_limit` activations again before it raises another request.
- R5: Row 0 queues only row 1, and the highest row (15 at default size) queues only the row below it. A neighbour that would fall outside the row range is never requested.
- R6: A cycle with `win_tick` high clears every count. An activation in the same cycle counts as the first activation of the new window.
- R7: While `mac_limit` is zero, no activation queues anything.
- R8: A victim row that is already waiting in the queue is not written a second time.
- R9: The queue holds up to 4 victims and releases them in order. `ref_valid` and `ref_row` stay unchanged while `ref_ready` is low. Each cycle with both `ref_valid` and `ref_ready` high removes exactly one entry.
- R10: When the queue lacks room for all new victims of an activation, that activation queues nothing and clears nothing, and the count still increments. The next activation of the same row raises the request again.
- R11: After reset, `ref_valid` is low and every count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A row-activate command is issued this cycle |
| act_row | input | ROW_W (4) | Row address of the activate |
| win_tick | input | 1 | Starts a new counting window |
| mac_limit | input | CNT_W (8) | Activation threshold; zero disables detection |
| ref_valid | output | 1 | A victim refresh request is offered |
| ref_ready | input | 1 | Scheduler accepts the offered request |
| ref_row | output | ROW_W (4) | Row address of the victim to refresh |

## Verification
The assertions assume that `act_row` and `mac_limit` are known whenever `act_valid` is high. They also assume that `mac_limit` does not change in the same cycle as an activation that depends on it. The stimulus changes the threshold and raises the window tick only while no activation is in flight, except in the one case meant to test a tick and an activation together. It drives every input one time unit after the rising edge. Activations are grouped so that each expected victim can be computed from per-row counts alone, before it appears on the outputs. The queue-full case is built by holding `ref_ready` low, so the room seen by each activation is known in advance.

// File: rtl/rvr_pkg.sv
package rvr_pkg;

    // Output side of the victim queue
    typedef enum logic {
        Q_EMPTY = 1'b0,
        Q_OFFER = 1'b1
    } q_state_e;

endpackage

// File: rtl/rvr_act_counter.sv
module rvr_act_counter #(
    parameter int ROW_W = 4,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [ROW_W-1:0]     act_row,
    input  logic                 win_tick,
    input  logic [CNT_W-1:0]     mac_limit,
    input  logic [(1<<ROW_W)-1:0] pending,
    input  logic [1:0]           room,
    output logic                 push_lo,
    output logic                 push_hi,
    output logic [ROW_W-1:0]     lo_row,
    output logic [ROW_W-1:0]     hi_row
);
    localparam int ROWS = 1 << ROW_W;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;
    localparam logic [ROW_W-1:0] TWO     = ROW_W'(2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [ROWS];

    logic [CNT_W-1:0] cur, inc, left2, right2;
    logic [CNT_W:0]   sum_lo, sum_hi, mac_ext;
    logic             det_en, single, lo_flag, hi_flag, new_lo, new_hi;
    logic [1:0]       need;
    logic             commit, clr_left, clr_right;

    // Effective counts: a tick in this cycle makes the old window invisible
    always_comb begin
        cur    = win_tick ? '0 : cnt_q[act_row];
        left2  = (win_tick || act_row < TWO) ? '0 : cnt_q[act_row - TWO];
        right2 = (win_tick || act_row > ROW_MAX - TWO) ? '0 : cnt_q[act_row + TWO];
        inc    = (cur == CNT_MAX) ? cur : cur + CNT_W'(1);
        sum_lo  = {1'b0, left2} + {1'b0, inc};
        sum_hi  = {1'b0, inc} + {1'b0, right2};
        mac_ext = {1'b0, mac_limit};
    end

    // Trigger evaluation for the two possible victims of this activation
    always_comb begin
        det_en  = act_valid && (mac_limit != '0);
        single  = det_en && ({1'b0, inc} >= mac_ext);
        lo_flag = det_en && (act_row != '0)     && (sum_lo >= mac_ext);
        hi_flag = det_en && (act_row != ROW_MAX) && (sum_hi >= mac_ext);
        lo_row  = act_row - ROW_W'(1);
        hi_row  = act_row + ROW_W'(1);
        new_lo  = lo_flag && !pending[lo_row];
        new_hi  = hi_flag && !pending[hi_row];
        need    = {1'b0, new_lo} + {1'b0, new_hi};
        commit  = (lo_flag || hi_flag) && (need <= room);
        push_lo = commit && new_lo;
        push_hi = commit && new_hi;
        clr_left  = commit && lo_flag && !single && (act_row >= TWO);
        clr_right = commit && hi_flag && !single && (act_row <= ROW_MAX - TWO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) cnt_q[i] <= '0;
        end else begin
            if (win_tick) begin
                for (int i = 0; i < ROWS; i++) cnt_q[i] <= '0;
            end
            if (act_valid) cnt_q[act_row] <= commit ? '0 : inc;
            if (clr_left)  cnt_q[act_row - TWO] <= '0;
            if (clr_right) cnt_q[act_row + TWO] <= '0;
        end
    end

    logic cnt_any;
    always_comb begin
        cnt_any = 1'b0;
        for (int i = 0; i < ROWS; i++) cnt_any = cnt_any | (cnt_q[i] != '0);
    end

    assert_mac_zero_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_limit == '0) |-> !(push_lo || push_hi));

    assert_edge_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_row == '0) |-> !push_lo);

    assert_edge_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_row == ROW_MAX) |-> !push_hi);

    assert_tick_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_tick && !act_valid) |=> !cnt_any);

    assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_lo || push_hi) |=> (cnt_q[$past(act_row)] == '0));

endmodule

// File: rtl/rvr_victim_queue.sv
module rvr_victim_queue
    import rvr_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_lo,
    input  logic                  push_hi,
    input  logic [ROW_W-1:0]      lo_row,
    input  logic [ROW_W-1:0]      hi_row,
    input  logic                  ref_ready,
    output logic [(1<<ROW_W)-1:0] pending,
    output logic [1:0]            room,
    output logic                  ref_valid,
    output logic [ROW_W-1:0]      ref_row
);
    // DEPTH must be a power of two so the pointers wrap naturally
    localparam int ROWS  = 1 << ROW_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W:0] DEPTH_V = (OCC_W+1)'(DEPTH);

    q_state_e         state_q, state_d;
    logic [ROW_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [OCC_W-1:0] occ_q, occ_d;
    logic [ROWS-1:0]  pend_q;
    logic [1:0]       npush;
    logic             pop;
    logic [OCC_W:0]   avail;

    always_comb begin
        pop   = ref_valid && ref_ready;
        npush = {1'b0, push_lo} + {1'b0, push_hi};
        occ_d = occ_q + OCC_W'(npush) - OCC_W'(pop);
        avail = DEPTH_V - {1'b0, occ_q} + {{OCC_W{1'b0}}, pop};
        room  = (avail >= (OCC_W+1)'(2)) ? 2'd2 : avail[1:0];
        pending = pend_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (npush != 2'd0) state_d = Q_OFFER;
            Q_OFFER: if (occ_d == '0)   state_d = Q_EMPTY;
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Storage, pointers and pending map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
            pend_q   <= '0;
        end else begin
            if (push_lo) mem_q[wr_ptr_q] <= lo_row;
            if (push_hi) mem_q[wr_ptr_q + PTR_W'(push_lo)] <= hi_row;
            wr_ptr_q <= wr_ptr_q + PTR_W'(npush);
            rd_ptr_q <= rd_ptr_q + PTR_W'(pop);
            occ_q    <= occ_d;
            if (pop)     pend_q[ref_row] <= 1'b0;
            if (push_lo) pend_q[lo_row]  <= 1'b1;
            if (push_hi) pend_q[hi_row]  <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ref_valid = (state_q == Q_OFFER);
        ref_row   = mem_q[rd_ptr_q];
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_row)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, occ_q} <= DEPTH_V);

    assert_valid_matches_occ_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid == (occ_q != '0));

    assert_pending_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_q) == int'(occ_q));

endmodule

// File: rtl/rvr_victim_refresher.sv
module rvr_victim_refresher #(
    parameter int ROW_W  = 4,
    parameter int CNT_W  = 8,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [ROW_W-1:0] act_row,
    input  logic             win_tick,
    input  logic [CNT_W-1:0] mac_limit,
    output logic             ref_valid,
    input  logic             ref_ready,
    output logic [ROW_W-1:0] ref_row
);
    localparam int ROWS = 1 << ROW_W;

    logic [ROWS-1:0]  pending;
    logic [1:0]       room;
    logic             push_lo, push_hi;
    logic [ROW_W-1:0] lo_row, hi_row;

    rvr_act_counter #(.ROW_W(ROW_W), .CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_valid(act_valid),
        .act_row  (act_row),
        .win_tick (win_tick),
        .mac_limit(mac_limit),
        .pending  (pending),
        .room     (room),
        .push_lo  (push_lo),
        .push_hi  (push_hi),
        .lo_row   (lo_row),
        .hi_row   (hi_row)
    );

    rvr_victim_queue #(.ROW_W(ROW_W), .DEPTH(QDEPTH)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_lo  (push_lo),
        .push_hi  (push_hi),
        .lo_row   (lo_row),
        .hi_row   (hi_row),
        .ref_ready(ref_ready),
        .pending  (pending),
        .room     (room),
        .ref_valid(ref_valid),
        .ref_row  (ref_row)
    );

    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |=> !ref_valid);

endmodule

// File: tb/rvr_victim_refresher_tb.sv
module rvr_victim_refresher_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_valid = 1'b0;
    logic [3:0] act_row = '0;
    logic       win_tick = 1'b0;
    logic [7:0] mac_limit = 8'd4;
    logic       ref_valid;
    logic       ref_ready = 1'b0;
    logic [3:0] ref_row;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rvr_victim_refresher dut_i (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
        .win_tick(win_tick), .mac_limit(mac_limit), .ref_valid(ref_valid),
        .ref_ready(ref_ready), .ref_row(ref_row)
    );

    // Monitor: every accepted request is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && ref_valid && ref_ready && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected request: ref_row=%0d expected none", ref_row);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (ref_row !== e) begin
                    errors++;
                    $display("FAIL %s: ref_row=%0d expected %0d", t, ref_row, e);
                end
            end
        end
    end

    task automatic expect_row(input logic [3:0] r, input string t);
        exp_q.push_back(r);
        tag_q.push_back(t);
    endtask

    task automatic act(input logic [3:0] r, input int n);
        for (int k = 0; k < n; k++) begin
            act_valid = 1'b1;
            act_row   = r;
            @(posedge clk); #1;
        end
        act_valid = 1'b0;
    endtask

    task automatic tick();
        win_tick = 1'b1;
        @(posedge clk); #1;
        win_tick = 1'b0;
    endtask

    task automatic check(input bit ok, input string t, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act_v, exp_v);
        end
    endtask

    // Wait for the scoreboard to drain, then confirm nothing further is offered
    task automatic settle(input string t);
        for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, {t, " pending expectations"}, exp_q.size(), 0);
        check(ref_valid == 1'b0, {t, " queue idle"}, ref_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        check(ref_valid == 1'b0, "R11 reset valid", ref_valid, 0);
        ref_ready = 1'b1;

        // R1/R2: threshold 4 on row 5, lower victim first
        act(4'd5, 3);
        repeat (2) @(posedge clk); #1;
        check(ref_valid == 1'b0, "R1 below limit", ref_valid, 0);
        expect_row(4'd4, "R2 low victim");
        expect_row(4'd6, "R2 high victim");
        act(4'd5, 1);
        settle("R2");

        // R4: own count cleared after trigger
        act(4'd5, 3);
        settle("R4 no retrigger");
        expect_row(4'd4, "R4 retrigger low");
        expect_row(4'd6, "R4 retrigger high");
        act(4'd5, 1);
        settle("R4");

        // R6: tick clears counts
        tick();
        act(4'd7, 3);
        tick();
        act(4'd7, 3);
        settle("R6 tick clear");

        // R3: neighbour sum flags row 9
        tick();
        act(4'd8, 2);
        act(4'd10, 1);
        expect_row(4'd9, "R3 pair victim");
        act(4'd10, 1);
        settle("R3");
        act(4'd10, 2);
        settle("R3 neighbours cleared");

        // R5: edge rows
        tick();
        expect_row(4'd1, "R5 row0 victim");
        act(4'd0, 4);
        settle("R5 low edge");
        expect_row(4'd14, "R5 row15 victim");
        act(4'd15, 4);
        settle("R5 high edge");

        // R7: threshold zero disables
        tick();
        mac_limit = 8'd0;
        act(4'd3, 10);
        settle("R7 disabled");

        // R8: dedup of a pending victim
        mac_limit = 8'd2;
        tick();
        ref_ready = 1'b0;
        act(4'd5, 2);
        act(4'd7, 2);
        expect_row(4'd4, "R8 first");
        expect_row(4'd6, "R8 shared");
        expect_row(4'd8, "R8 third");
        ref_ready = 1'b1;
        settle("R8");

        // R9/R10: full queue holds, deferral re-triggers
        tick();
        ref_ready = 1'b0;
        act(4'd2, 2);
        act(4'd11, 2);
        act(4'd6, 2);
        repeat (3) @(posedge clk); #1;
        check(ref_valid == 1'b1, "R9 valid held", ref_valid, 1);
        check(ref_row == 4'd1, "R9 head held", ref_row, 1);
        expect_row(4'd1, "R9 order 1");
        expect_row(4'd3, "R9 order 2");
        expect_row(4'd10, "R9 order 3");
        expect_row(4'd12, "R9 order 4");
        ref_ready = 1'b1;
        settle("R10 deferred nothing queued");
        expect_row(4'd5, "R10 deferred low");
        expect_row(4'd7, "R10 deferred high");
        act(4'd6, 1);
        settle("R10");

        // R6: activation in the tick cycle is first of the new window
        tick();
        act(4'd9, 1);
        win_tick = 1'b1;
        act(4'd9, 1);
        win_tick = 1'b0;
        settle("R6 tick with activation");
        expect_row(4'd8, "R6 new window low");
        expect_row(4'd10, "R6 new window high");
        act(4'd9, 1);
        settle("R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule